// File: doc/BRIEF.md
# Frequency Strap Capture and Code Selection

This block sits in front of a clock synthesizer. While power-on reset is active, a small set of shared pins serve as configuration inputs. Their levels are sampled once, on the first clock edge after reset is released. After one more cycle the block raises the output enables, and the same pins then carry clocks. The strap pins have pull-downs, so a pin nobody drives is seen as 0.

The synthesizer is steered by a five-bit frequency code. The code comes either from the sampled straps or from a software-writable frequency register, and a source bit in that register chooses between them. From the active code the block decodes three things: a high-impedance request (code 0), a crystal bypass request (code 1, where the outputs run at the crystal frequency divided by 6, 12 and 24), and a table index for every other code. It also produces a combined down-spread enable. A second register holds the peripheral-clock frequency code.

The frequency register, the peripheral register and the latched straps can all be read back through a small read port.

Top module: `freq_strap_ctrl`

## Requirements
- R1: The straps are sampled on the first rising clock edge at which rst_n is high. After that edge, changes on strap_in have no effect until the next reset.
- R2: All bits of strap_oe are 0 while reset is active and after the capture edge. They become 1 after the second rising edge following reset release, and return to 0 as soon as reset is asserted.
- R3: Right after capture, the frequency register (rd_sel=0) reads the straps in bits [2:0] with every other bit 0. The peripheral register (rd_sel=1) reads 0x00. rd_sel=2 returns the latched straps in bits [2:0], and rd_sel=3 returns 0.
- R4: Bit 7 of the frequency register selects the code source, 0 for straps and 1 for register. With straps the active code is {2'b00, straps}; with register it is bits [4:0]. A write takes effect on the outputs right after the clock edge that stores it.
- R5: cpu_hiz is 1 exactly when the active code is 0. cpu_bypass is 1 exactly when the active code is 1.
- R6: freq_idx equals the active code minus 2 for codes 2..31, and 0 for codes 0 and 1.
- R7: spread_en is 1 only when all three of the following are 1: active code bit 4, frequency register bit 6 and peripheral register bit 4. The spread is a fixed -0.5% down-spread.
- R8: src_idx equals peripheral register bits [3:0]. The peripheral register stores bits 7 and 4..0; bits 6..5 read 0.
- R9: Frequency register bit 5 reads 0 whatever is written to it. A write presented on the capture edge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous assert |
| strap_in | input | 3 | Levels seen on the shared strap pins |
| strap_oe | output | 3 | Clock output enables for the shared pins |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 frequency register, 1 peripheral register |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Read select: 0 freq, 1 peripheral, 2 straps, 3 zero |
| rd_data | output | 8 | Read data (combinational) |
| cpu_code | output | 5 | Active frequency code |
| cpu_hiz | output | 1 | High-impedance request |
| cpu_bypass | output | 1 | Crystal bypass request |
| spread_en | output | 1 | Combined down-spread enable |
| freq_idx | output | 5 | Table index for the active code |
| src_idx | output | 4 | Peripheral frequency index |

## Verification
The code outputs, the decoded flags, spread_en, src_idx and rd_data all follow the registers combinationally. They are therefore due directly after the edge that stores a write, and the bench drives writes on a falling edge and checks on the next falling edge. Register contents after capture can be seen one half-cycle after the capture edge. strap_oe needs one further edge, so the bench checks it low at the falling edge after capture and high one cycle later. rd_sel is combinational and is settled with a short delay before each read check.

// File: rtl/freq_strap_pkg.sv
`timescale 1ns/1ps
package freq_strap_pkg;
  localparam int REG_W      = 8;
  localparam int CODE_W     = 5;
  localparam int SRC_IDX_W  = 4;
  localparam int SEL_BIT    = 7;
  localparam int SPRD_BIT   = 6;
  localparam int CODE_HI    = CODE_W - 1;
  localparam logic [REG_W-1:0] FREQ_WMASK = 8'b1101_1111;
  localparam logic [REG_W-1:0] SRC_WMASK  = 8'b1001_1111;
  localparam logic [CODE_W-1:0] CODE_HIZ    = 5'd0;
  localparam logic [CODE_W-1:0] CODE_BYPASS = 5'd1;

  typedef enum logic [1:0] {
    RD_FREQ  = 2'd0,
    RD_SRC   = 2'd1,
    RD_STRAP = 2'd2,
    RD_NONE  = 2'd3
  } rd_sel_e;

  function automatic logic [CODE_W-1:0] code_to_idx(input logic [CODE_W-1:0] c);
    logic [CODE_W-1:0] r;
    if (c <= CODE_BYPASS) r = '0;
    else r = c - CODE_W'(2);
    return r;
  endfunction
endpackage

// File: rtl/strap_capture.sv
`timescale 1ns/1ps
module strap_capture #(
  parameter int NUM_STRAPS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_STRAPS-1:0] strap_in,
  output logic [NUM_STRAPS-1:0] strap_q,
  output logic                  cap_done,
  output logic                  capture_now,
  output logic [NUM_STRAPS-1:0] strap_oe
);
  logic oe_q;

  assign capture_now = rst_n & ~cap_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q  <= '0;
      cap_done <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      if (!cap_done) begin
        strap_q  <= strap_in;
        cap_done <= 1'b1;
      end
      oe_q <= cap_done;
    end
  end

  for (genvar i = 0; i < NUM_STRAPS; i++) begin : g_oe
    assign strap_oe[i] = oe_q;
  end

  // R2: enables only after capture has completed one cycle earlier
  a_r2_oe_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_oe != '0) |-> $past(cap_done));
  // R1: latched straps never move once captured
  a_r1_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_done && $past(cap_done)) |-> $stable(strap_q));
endmodule

// File: rtl/cfg_regs.sv
`timescale 1ns/1ps
module cfg_regs
  import freq_strap_pkg::*;
#(
  parameter int NUM_STRAPS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  capture_now,
  input  logic                  cap_done,
  input  logic [NUM_STRAPS-1:0] strap_in,
  input  logic [NUM_STRAPS-1:0] strap_q,
  input  logic                  wr_en,
  input  logic                  wr_sel,
  input  logic [REG_W-1:0]      wr_data,
  input  logic [1:0]            rd_sel,
  output logic [REG_W-1:0]      rd_data,
  output logic                  use_reg,
  output logic                  sprd_ctl,
  output logic [CODE_W-1:0]     reg_code,
  output logic [CODE_W-1:0]     src_code
);
  logic [REG_W-1:0] freq_reg, src_reg, strap_ext, strap_q_ext;
  logic             wr_ok;

  always_comb begin
    strap_ext = '0;
    strap_ext[NUM_STRAPS-1:0] = strap_in;
    strap_q_ext = '0;
    strap_q_ext[NUM_STRAPS-1:0] = strap_q;
  end

  assign wr_ok = wr_en & cap_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_reg <= '0;
      src_reg  <= '0;
    end else if (capture_now) begin
      freq_reg <= strap_ext;
      src_reg  <= '0;
    end else if (wr_ok) begin
      if (!wr_sel) freq_reg <= wr_data & FREQ_WMASK;
      else         src_reg  <= wr_data & SRC_WMASK;
    end
  end

  always_comb begin
    case (rd_sel_e'(rd_sel))
      RD_FREQ:  rd_data = freq_reg;
      RD_SRC:   rd_data = src_reg;
      RD_STRAP: rd_data = strap_q_ext;
      default:  rd_data = '0;
    endcase
  end

  assign use_reg  = freq_reg[SEL_BIT];
  assign sprd_ctl = freq_reg[SPRD_BIT];
  assign reg_code = freq_reg[CODE_W-1:0];
  assign src_code = src_reg[CODE_W-1:0];

  // R3: mirror bits take the sampled straps on the capture edge
  a_r3_mirror_load: assert property (@(posedge clk) disable iff (!rst_n)
    capture_now |=> (reg_code == CODE_W'($past(strap_ext)) && !use_reg));
  // R4: source bit follows a write on the next edge
  a_r4_source_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !wr_sel) |=> (use_reg == $past(wr_data[SEL_BIT])));
  // R9: the capture edge leaves no room for a write
  a_r9_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
    capture_now |=> (src_code == '0));
endmodule

// File: rtl/code_select.sv
`timescale 1ns/1ps
module code_select
  import freq_strap_pkg::*;
#(
  parameter int NUM_STRAPS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_STRAPS-1:0] strap_q,
  input  logic                  use_reg,
  input  logic                  sprd_ctl,
  input  logic [CODE_W-1:0]     reg_code,
  input  logic [CODE_W-1:0]     src_code,
  output logic [CODE_W-1:0]     cpu_code,
  output logic                  cpu_hiz,
  output logic                  cpu_bypass,
  output logic                  spread_en,
  output logic [CODE_W-1:0]     freq_idx,
  output logic [SRC_IDX_W-1:0]  src_idx
);
  logic [CODE_W-1:0] strap_code;

  always_comb begin
    strap_code = '0;
    strap_code[NUM_STRAPS-1:0] = strap_q;
  end

  assign cpu_code   = use_reg ? reg_code : strap_code;
  assign cpu_hiz    = (cpu_code == CODE_HIZ);
  assign cpu_bypass = (cpu_code == CODE_BYPASS);
  assign freq_idx   = code_to_idx(cpu_code);
  assign spread_en  = cpu_code[CODE_HI] & sprd_ctl & src_code[CODE_HI];
  assign src_idx    = src_code[SRC_IDX_W-1:0];

  // R5: at most one special mode at a time
  a_r5_modes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_hiz, cpu_bypass}));
  // R7: spread implies a spread-group code, never a special mode
  a_r7_spread_group: assert property (@(posedge clk) disable iff (!rst_n)
    spread_en |-> (!cpu_hiz && !cpu_bypass && sprd_ctl));
  // R4: strap source passes the latched straps through
  a_r4_strap_source: assert property (@(posedge clk) disable iff (!rst_n)
    !use_reg |-> (cpu_code[NUM_STRAPS-1:0] == strap_q));
  // R6: index plus two recovers ordinary codes
  a_r6_index_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_hiz && !cpu_bypass) |-> ({1'b0, freq_idx} + 6'd2 == {1'b0, cpu_code}));
endmodule

// File: rtl/freq_strap_ctrl.sv
`timescale 1ns/1ps
module freq_strap_ctrl
  import freq_strap_pkg::*;
#(
  parameter int NUM_STRAPS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_STRAPS-1:0] strap_in,
  output logic [NUM_STRAPS-1:0] strap_oe,
  input  logic                  wr_en,
  input  logic                  wr_sel,
  input  logic [REG_W-1:0]      wr_data,
  input  logic [1:0]            rd_sel,
  output logic [REG_W-1:0]      rd_data,
  output logic [CODE_W-1:0]     cpu_code,
  output logic                  cpu_hiz,
  output logic                  cpu_bypass,
  output logic                  spread_en,
  output logic [CODE_W-1:0]     freq_idx,
  output logic [SRC_IDX_W-1:0]  src_idx
);
  logic [NUM_STRAPS-1:0] strap_q;
  logic                  cap_done, capture_now;
  logic                  use_reg, sprd_ctl;
  logic [CODE_W-1:0]     reg_code, src_code;

  strap_capture #(.NUM_STRAPS(NUM_STRAPS)) u_cap (
    .clk(clk), .rst_n(rst_n), .strap_in(strap_in), .strap_q(strap_q),
    .cap_done(cap_done), .capture_now(capture_now), .strap_oe(strap_oe)
  );

  cfg_regs #(.NUM_STRAPS(NUM_STRAPS)) u_regs (
    .clk(clk), .rst_n(rst_n), .capture_now(capture_now), .cap_done(cap_done),
    .strap_in(strap_in), .strap_q(strap_q), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .use_reg(use_reg),
    .sprd_ctl(sprd_ctl), .reg_code(reg_code), .src_code(src_code)
  );

  code_select #(.NUM_STRAPS(NUM_STRAPS)) u_sel (
    .clk(clk), .rst_n(rst_n), .strap_q(strap_q), .use_reg(use_reg),
    .sprd_ctl(sprd_ctl), .reg_code(reg_code), .src_code(src_code),
    .cpu_code(cpu_code), .cpu_hiz(cpu_hiz), .cpu_bypass(cpu_bypass),
    .spread_en(spread_en), .freq_idx(freq_idx), .src_idx(src_idx)
  );
endmodule

// File: tb/test_freq_strap_ctrl.sv
`timescale 1ns/1ps
module test_freq_strap_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] strap_in = 3'b000;
  logic [2:0] strap_oe;
  logic       wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] rd_sel = 2'd0;
  logic [7:0] rd_data;
  logic [4:0] cpu_code, freq_idx;
  logic       cpu_hiz, cpu_bypass, spread_en;
  logic [3:0] src_idx;

  int checks = 0, errors = 0;
  logic [7:0] m_freq, m_src;
  logic [2:0] m_strap;

  always #10 clk = ~clk;

  freq_strap_ctrl i_freq_strap_ctrl (
    .clk(clk), .rst_n(rst_n), .strap_in(strap_in), .strap_oe(strap_oe),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .cpu_code(cpu_code), .cpu_hiz(cpu_hiz),
    .cpu_bypass(cpu_bypass), .spread_en(spread_en), .freq_idx(freq_idx),
    .src_idx(src_idx)
  );

  function automatic logic [4:0] exp_code();
    return m_freq[7] ? m_freq[4:0] : {2'b00, m_strap};
  endfunction
  function automatic logic [4:0] exp_idx(input logic [4:0] c);
    if (c == 5'd0 || c == 5'd1) return 5'd0;
    return c - 5'd2;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_reads();
    rd_sel = 2'd0; #1 check("R3/R9 freq reg read", rd_data, m_freq);
    rd_sel = 2'd1; #1 check("R8 src reg read", rd_data, m_src);
    rd_sel = 2'd2; #1 check("R3/R1 strap read", rd_data, {5'b0, m_strap});
    rd_sel = 2'd3; #1 check("R3 unused read", rd_data, 8'h00);
  endtask

  task automatic check_outputs();
    logic [4:0] c;
    c = exp_code();
    check("R4 cpu_code", cpu_code, c);
    check("R5 cpu_hiz", cpu_hiz, c == 5'd0);
    check("R5 cpu_bypass", cpu_bypass, c == 5'd1);
    check("R6 freq_idx", freq_idx, exp_idx(c));
    check("R7 spread_en", spread_en, c[4] & m_freq[6] & m_src[4]);
    check("R8 src_idx", src_idx, m_src[3:0]);
  endtask

  task automatic do_write(input logic sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (!sel) m_freq = d & 8'hDF;
    else      m_src  = d & 8'h9F;
    check_outputs();
    check_reads();
  endtask

  task automatic do_reset(input logic [2:0] s, input logic wr_on_capture);
    @(negedge clk);
    rst_n = 1'b0;
    strap_in = s;
    #1 check("R2 oe low in reset", strap_oe, 3'b000);
    repeat (3) @(negedge clk);
    check("R2 oe low in reset held", strap_oe, 3'b000);
    rst_n = 1'b1;
    if (wr_on_capture) begin
      wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'hFF;
    end
    @(negedge clk);
    wr_en = 1'b0;
    m_strap = s; m_freq = {5'b0, s}; m_src = 8'h00;
    check("R2 oe low after capture edge", strap_oe, 3'b000);
    strap_in = ~s;
    check_reads();
    check_outputs();
    @(negedge clk);
    check("R2 oe high after second edge", strap_oe, 3'b111);
    check("R1 strap change ignored", cpu_code, {2'b00, s});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    do_reset(3'b101, 1'b0);
    // R5: straps at 0 give high impedance, at 1 give bypass
    do_reset(3'b000, 1'b0);
    check("R5 strap hiz", cpu_hiz, 1'b1);
    do_reset(3'b001, 1'b1);  // R9: write on capture edge ignored
    check("R5 strap bypass", cpu_bypass, 1'b1);
    check("R9 capture write ignored", rd_data, 8'h00);
    do_reset(3'b110, 1'b0);

    do_write(1'b0, 8'h80);            // R4 register source, code 0
    do_write(1'b0, 8'h81);            // code 1
    do_write(1'b0, 8'h82);            // R6 lowest index
    do_write(1'b1, 8'h10);
    do_write(1'b0, 8'hFF);            // R7 all three set, R9 bit5 dropped
    check("R7 spread full", spread_en, 1'b1);
    do_write(1'b1, 8'hEF);            // R8 bits 6..5 dropped, spread off
    check("R7 spread needs src bit", spread_en, 1'b0);
    do_write(1'b0, 8'h5F);            // R4 back to straps
    check("R4 back to straps", cpu_code, 5'b00110);

    for (int n = 0; n < 300; n++) begin
      if (($urandom % 4) == 0) strap_in = 3'($urandom);
      do_write(1'($urandom), 8'($urandom));
    end

    do_reset(3'b011, 1'b0);
    check_outputs();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule